// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control side of a 10-bit successive-approximation converter. It takes an enable bit, a start request, a free-running mode bit, a 3-bit clock divider select and a channel select. From these it makes a slow converter clock by dividing the system clock. On that clock it steps each conversion through a sample phase, ten bit-decision cycles and a result transfer. The analog comparator is outside the block. The block drives a trial code on `dac_code` and reads back one comparator decision per bit on `cmp_hi`.

After a start request, the sequencer waits for the next converter clock tick and then runs a conversion of a fixed length. The first conversion after the block is enabled is an extended one, with a longer sample phase. When a conversion ends, the block stores the result, pulses `done` and sets a sticky interrupt flag. In single mode it then goes back to idle. In free-running mode it starts the next conversion on the same tick. Clearing the enable bit aborts whatever is in progress.

The control is a five-state machine:

| State | Meaning |
|---|---|
| IDLE | Waiting for a start request. |
| ARMED | A start has been accepted; waiting for the next tick. |
| SAMPLE | Sample-and-hold phase. |
| CONVERT | The ten bit decisions. |
| XFER | The final cycle, in which the result is transferred. |

The transitions are:

| From | To | Condition |
|---|---|---|
| IDLE | ARMED | `start` while enabled |
| ARMED | SAMPLE | next tick |
| SAMPLE | CONVERT | tick ending the last sample cycle |
| CONVERT | XFER | tick after the least significant decision |
| XFER | SAMPLE | tick, with free-running mode set |
| XFER | IDLE | tick, with free-running mode clear |
| any state | IDLE | `en` low |

Top module: `adc_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `irq`, `sampling` and `result` are all 0. While `en` is low, a `start` pulse is ignored: `busy` stays 0 and no `done` appears.
- R2: The converter clock period N is set by `psel`. Codes 0 and 1 both give N = 2 system clocks, and code k from 2 to 7 gives N = 2^k. Counting the first rising edge with `en` high as edge 1, ticks fall on the edges whose index is a multiple of N.
- R3: A `start` seen at edge m sets `busy` from that edge on. The conversion begins at the first tick edge strictly after m. `busy` stays 1 until the completion edge, and in single mode it reads 0 after it.
- R4: A conversion lasts T ticks, so `done` goes high after edge (first tick edge) + T·N. T is 25 for the first conversion after `en` rises and 13 for every later one.
- R5: `sampling` is high for exactly (T−11)·N system clocks of each conversion. Then the register decides one bit per tick, MSB first: a bit is kept when `cmp_hi`=1 for the trial code. `result` ends as the largest code not above the comparator threshold, limited to 1023.
- R6: In free-running mode, the next conversion starts on the completion tick. Completions are then 13·N clocks apart and `busy` stays 1. After free-running mode is cleared, the conversion in progress completes and the block goes idle.
- R7: `chan_active` follows `chan_sel` while the block is enabled and no conversion is running. A change of `chan_sel` made during a conversion appears only after that conversion ends.
- R8: `done` is a one-cycle pulse, and `irq` is set on the same edge. `irq_ack` clears `irq`. If a completion and `irq_ack` fall in the same cycle, `irq` is left set.
- R9: Dropping `en` during a conversion aborts it, clears `busy` and suppresses `done`. The next conversion after re-enabling is an extended one.
- R10: A `start` pulse while `busy` is high is ignored: it does not change the completion time, and it is not queued for later.
- R11: While `en` is low, `chan_active` holds its value whatever `chan_sel` does. It resumes following `chan_sel` once `en` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable; low holds the divider in reset and aborts |
| start | input | 1 | Start request pulse |
| free_run | input | 1 | 1 selects free-running mode |
| psel | input | 3 | Divider select code |
| chan_sel | input | 3 | Requested input channel |
| cmp_hi | input | 1 | Comparator decision: input at or above the trial code |
| irq_ack | input | 1 | Clears the interrupt flag |
| busy | output | 1 | Start bit readback; 1 while a conversion is pending or running |
| sampling | output | 1 | Sample-and-hold phase active |
| dac_code | output | 10 | Trial code for the comparison DAC |
| chan_active | output | 3 | Channel applied to the input multiplexer |
| result | output | 10 | Last completed conversion result |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Sticky completion interrupt flag |

## Verification
Two functions can land on the same edge: the completion that sets `irq`, and a software acknowledge that clears it. The bench works out the completion edge from the divider period, the start edge and the conversion length. It then drives `irq_ack` so that it is sampled on exactly that edge, and expects `irq` to read 1 afterwards. A second overlap is a `start` pulse arriving while a conversion is running. The bench judges it in two ways: the completion edge must still match the formula, and `busy` must read 0 one cycle after completion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SAMPLE,
        ST_CONVERT,
        ST_XFER
    } seq_state_t;

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
    parameter int STAGES = 7,
    parameter int SEL_W  = $clog2(STAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [STAGES-1:0] cnt_q;
    logic [STAGES-1:0] tap_mask;
    int unsigned       depth;

    // Held at zero while disabled; counts every cycle while enabled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (!en) cnt_q <= '0;
        else          cnt_q <= cnt_q + 1'b1;
    end

    // Codes 0 and 1 both select the shallowest tap.
    assign depth = (sel < SEL_W'(2)) ? 1 : int'(sel);

    for (genvar g = 0; g < STAGES; g++) begin : g_tap
        assign tap_mask[g] = (g < depth);
    end

    assign tick = en && ((cnt_q & tap_mask) == tap_mask);

    // R2: the smallest period is two clocks, so ticks never come back to back.
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/adc_sar.sv
module adc_sar #(
    parameter int BITS = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic            step,
    input  logic            cmp_hi,
    output logic [BITS-1:0] trial
);

    logic [BITS-1:0] val_q;
    logic [BITS-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q  <= '0;
            mask_q <= '0;
        end else if (init) begin
            val_q  <= {1'b1, {(BITS-1){1'b0}}};
            mask_q <= {1'b1, {(BITS-1){1'b0}}};
        end else if (step) begin
            val_q  <= (cmp_hi ? val_q : (val_q & ~mask_q)) | (mask_q >> 1);
            mask_q <= mask_q >> 1;
        end
    end

    assign trial = val_q;

    // R5: at most one bit is under trial at any time.
    a_r5_one_trial_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_q));

    // R5: a positive decision keeps the bit it was made for.
    a_r5_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !init && cmp_hi && (mask_q != '0)) |=> ((val_q & $past(mask_q)) != '0));

endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS     = 10,
    parameter int CH_W         = 3,
    parameter int PRESC_STAGES = 7,
    parameter int NORM_CYCLES  = 13,
    parameter int EXT_CYCLES   = 25,
    parameter int SEL_W        = $clog2(PRESC_STAGES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                start,
    input  logic                free_run,
    input  logic [SEL_W-1:0]    psel,
    input  logic [CH_W-1:0]     chan_sel,
    input  logic                cmp_hi,
    input  logic                irq_ack,
    output logic                busy,
    output logic                sampling,
    output logic [RES_BITS-1:0] dac_code,
    output logic [CH_W-1:0]     chan_active,
    output logic [RES_BITS-1:0] result,
    output logic                done,
    output logic                irq
);

    localparam int CNT_W = $clog2(EXT_CYCLES);
    localparam logic [CNT_W-1:0] N_SAMP_LAST = CNT_W'(NORM_CYCLES - RES_BITS - 2);
    localparam logic [CNT_W-1:0] E_SAMP_LAST = CNT_W'(EXT_CYCLES - RES_BITS - 2);
    localparam logic [CNT_W-1:0] N_LAST      = CNT_W'(NORM_CYCLES - 1);
    localparam logic [CNT_W-1:0] E_LAST      = CNT_W'(EXT_CYCLES - 1);

    seq_state_t          state_q, state_d;
    logic                tick;
    logic [CNT_W-1:0]    tcnt_q;
    logic                long_q, ext_pend_q;
    logic                busy_q, done_q, irq_q;
    logic [RES_BITS-1:0] result_q;
    logic [CH_W-1:0]     chan_q;
    logic [CNT_W-1:0]    samp_last, conv_last, bits_last;
    logic                conv_begin, complete, sar_step;
    logic [RES_BITS-1:0] trial;

    adc_prescaler #(.STAGES(PRESC_STAGES), .SEL_W(SEL_W)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .sel  (psel),
        .tick (tick)
    );

    adc_sar #(.BITS(RES_BITS)) u_sar (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (conv_begin),
        .step  (sar_step),
        .cmp_hi(cmp_hi),
        .trial (trial)
    );

    assign samp_last = long_q ? E_SAMP_LAST : N_SAMP_LAST;
    assign conv_last = long_q ? E_LAST : N_LAST;
    assign bits_last = conv_last - 1'b1;

    assign conv_begin = tick && ((state_q == ST_ARMED) || ((state_q == ST_XFER) && free_run));
    assign complete   = tick && (state_q == ST_XFER);
    assign sar_step   = tick && (state_q == ST_CONVERT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (start) state_d = ST_ARMED;
                ST_ARMED:   if (tick) state_d = ST_SAMPLE;
                ST_SAMPLE:  if (tick && (tcnt_q == samp_last)) state_d = ST_CONVERT;
                ST_CONVERT: if (tick && (tcnt_q == bits_last)) state_d = ST_XFER;
                ST_XFER:    if (tick) state_d = free_run ? ST_SAMPLE : ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs and sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q     <= '0;
            long_q     <= 1'b0;
            ext_pend_q <= 1'b1;
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            irq_q      <= 1'b0;
            result_q   <= '0;
            chan_q     <= '0;
        end else begin
            done_q <= complete;

            if (complete)     irq_q <= 1'b1;
            else if (irq_ack) irq_q <= 1'b0;

            if (complete) result_q <= trial;

            if (conv_begin)
                tcnt_q <= '0;
            else if (tick && ((state_q == ST_SAMPLE) || (state_q == ST_CONVERT)))
                tcnt_q <= tcnt_q + 1'b1;

            if (!en) begin
                ext_pend_q <= 1'b1;
                busy_q     <= 1'b0;
            end else begin
                if (conv_begin) begin
                    long_q     <= ext_pend_q;
                    ext_pend_q <= 1'b0;
                end
                if ((state_q == ST_IDLE) && start) busy_q <= 1'b1;
                else if (complete && !free_run)   busy_q <= 1'b0;
                if ((state_q == ST_IDLE) || (state_q == ST_ARMED) || (complete && free_run))
                    chan_q <= chan_sel;
            end
        end
    end

    assign busy        = busy_q;
    assign sampling    = (state_q == ST_SAMPLE);
    assign dac_code    = trial;
    assign chan_active = chan_q;
    assign result      = result_q;
    assign done        = done_q;
    assign irq         = irq_q;

    // R1 / R9: one cycle after the enable is low, the block is idle and not busy.
    a_r1_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((state_q == ST_IDLE) && !busy_q));

    // R3: any non-idle state is reflected in the start bit readback.
    a_r3_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> busy_q);

    // R4: the transfer cycle sits at the last index of the conversion.
    a_r4_xfer_index: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) |-> (tcnt_q == conv_last));

    // R7: the applied channel is frozen during sample and convert.
    a_r7_chan_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == ST_SAMPLE) || (state_q == ST_CONVERT)) &&
         (($past(state_q) == ST_SAMPLE) || ($past(state_q) == ST_CONVERT)))
        |-> $stable(chan_q));

    // R8: done is a single-cycle pulse.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R8: the flag is set whenever done is shown.
    a_r8_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> irq_q);

    // R9: disabling arms an extended conversion.
    a_r9_abort_extends: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |=> ext_pend_q);

endmodule

// File: tb/adc_sequencer_test.sv
`timescale 1ns/1ps
module adc_sequencer_test;

    logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0, start = 1'b0;
    logic        free_run = 1'b0, irq_ack = 1'b0;
    logic [2:0]  psel = 3'd0, chan_sel = 3'd0;
    logic [10:0] vin = 11'd0;
    logic        cmp_hi, busy, sampling, done, irq;
    logic [9:0]  dac_code, result;
    logic [2:0]  chan_active;

    int ecount = 0;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    // Edge index since enable rose: edge 1 is the first edge with en high.
    always @(posedge clk) begin
        if (!rst_n || !en) ecount <= 0;
        else               ecount <= ecount + 1;
    end

    // Comparator model: input at or above the trial code.
    assign cmp_hi = (vin >= {1'b0, dac_code});

    adc_sequencer uut (
        .clk(clk), .rst_n(rst_n), .en(en), .start(start), .free_run(free_run),
        .psel(psel), .chan_sel(chan_sel), .cmp_hi(cmp_hi), .irq_ack(irq_ack),
        .busy(busy), .sampling(sampling), .dac_code(dac_code),
        .chan_active(chan_active), .result(result), .done(done), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int div_of(input int p);
        return (p < 2) ? 2 : (1 << p);
    endfunction

    function automatic int code_of(input int v);
        return (v > 1023) ? 1023 : v;
    endfunction

    task automatic fresh_enable();
        @(negedge clk);
        en = 1'b0;
        free_run = 1'b0;
        repeat (2) @(negedge clk);
        en = 1'b1;
    endtask

    task automatic wait_done();
        for (int w = 0; w < 6000 && !done; w++) @(negedge clk);
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic run_conv(input int p, input int tlen, input int v,
                            input bit poke, input bit ack_race);
        int n, ms, exp_edge, samp_cnt, busy_drop;
        n = div_of(p);
        samp_cnt = 0;
        busy_drop = 0;
        @(negedge clk);
        psel = 3'(p);
        vin = 11'(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ms = ecount;
        chk("R3 busy after start", busy, 1);
        exp_edge = (ms / n + 1) * n + tlen * n;
        for (int w = 0; w < 4000 && !done; w++) begin
            if (sampling) samp_cnt++;
            if (!busy) busy_drop++;
            start   = poke && (w == 3 * n);
            irq_ack = ack_race && (ecount == exp_edge - 1);
            @(negedge clk);
        end
        start = 1'b0;
        irq_ack = 1'b0;
        chk("R4 R2 completion edge", ecount, exp_edge);
        chk("R3 busy held during conversion", busy_drop, 0);
        chk("R3 busy cleared at completion", busy, 0);
        chk("R5 result code", result, code_of(v));
        chk("R5 sample cycles", samp_cnt, (tlen - 11) * n);
        chk("R8 irq set with done", irq, 1);
        @(negedge clk);
        chk("R8 done lasts one cycle", done, 0);
        chk("R10 start while busy not queued", busy, 0);
        pulse_ack();
        chk("R8 irq cleared by ack", irq, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog R1..all actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int ms, exp_edge, cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset result", result, 0);
        chk("R1 reset sampling", sampling, 0);

        // R1: start while disabled is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1 start ignored while disabled", busy, 0);
        cnt = 0;
        for (int w = 0; w < 300; w++) begin
            if (done) cnt++;
            @(negedge clk);
        end
        chk("R1 no completion while disabled", cnt, 0);

        // R2 R4: every divider code, extended then normal conversions
        for (int p = 0; p < 8; p++) begin
            fresh_enable();
            run_conv(p, 25, (p * 131 + 7) % 1024, 1'b0, 1'b0);
            run_conv(p, 13, 1023 - p * 97, 1'b1, 1'b0);
            run_conv(p, 13, 1100, 1'b0, 1'b1);
        end

        // R5: near-exhaustive sweep of comparator thresholds
        for (int v = 0; v <= 1030; v += 7) run_conv(0, 13, v, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            int edge_v;
            edge_v = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 511 :
                     (k == 3) ? 512 : (k == 4) ? 1023 : 1024;
            run_conv(0, 13, edge_v, 1'b0, 1'b0);
        end

        // R6: free-running back-to-back conversions
        fresh_enable();
        psel = 3'd0;
        free_run = 1'b1;
        vin = 11'd300;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ms = ecount;
        exp_edge = (ms / 2 + 1) * 2 + 25 * 2;
        wait_done();
        chk("R6 first free-run completion", ecount, exp_edge);
        chk("R6 first free-run result", result, 300);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            vin = 11'(100 + i * 250);
            if (i == 2) free_run = 1'b0;
            exp_edge = exp_edge + 13 * 2;
            wait_done();
            chk("R6 free-run spacing", ecount, exp_edge);
            chk("R6 busy in free-run", busy, (i < 2) ? 1 : 0);
            chk("R6 free-run result", result, 100 + i * 250);
        end
        @(negedge clk);
        pulse_ack();

        // R7 R11: channel selection
        chan_sel = 3'd2;
        repeat (2) @(negedge clk);
        chk("R7 channel tracks when idle", chan_active, 2);
        psel = 3'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        chan_sel = 3'd5;
        repeat (4) @(negedge clk);
        chk("R7 channel change deferred", chan_active, 2);
        wait_done();
        @(negedge clk);
        chk("R7 channel applied after completion", chan_active, 5);
        pulse_ack();
        en = 1'b0;
        chan_sel = 3'd1;
        repeat (3) @(negedge clk);
        chk("R11 channel held while disabled", chan_active, 5);
        en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 channel resumes after enable", chan_active, 1);

        // R9: abort by disable, then extended conversion
        fresh_enable();
        run_conv(1, 25, 200, 1'b0, 1'b0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R9 busy cleared by abort", busy, 0);
        cnt = 0;
        for (int w = 0; w < 80; w++) begin
            if (done) cnt++;
            @(negedge clk);
        end
        chk("R9 no completion after abort", cnt, 0);
        en = 1'b1;
        run_conv(1, 25, 600, 1'b0, 1'b0);

        finish_run();
    end

endmodule